// File: doc/BRIEF.md
# Keyed-Enable Watchdog Timer

This block is a watchdog that is off after reset and can only be switched on by software. Software writes bytes to a write-only service port. The byte pair 0x1E followed by 0xE1 turns the watchdog on. Once it is running, the same pair restarts its count. Nothing else can switch it off except a hardware reset or its own timeout. The count itself cannot be read or written.

While armed, the block advances a counter once per machine cycle. A machine cycle is a fixed number of oscillator clocks. When the counter wraps past its all-ones value, the block raises a system reset request. That request lasts a fixed number of oscillator periods. A reset-out pin follows the request unless a pin-disable input is set. After the pulse the watchdog is disabled again.

Two status inputs, idle and power-down, pause the count. Power-down always freezes it. Idle freezes it only when a configuration input selects that.

Top module: `keyed_wdt`

## Requirements
- R1: After hardware reset (rst_n low) the watchdog is disabled. `sys_rst_o` and `rst_pin_o` stay 0 for any time without a key. A hardware reset while armed disables it again.
- R2: A write of 8'h1E followed, on the next write, by a write of 8'hE1 arms a disabled watchdog. The count starts from zero at the clock edge that takes the 8'hE1 write.
- R3: While armed and running, the count advances once every `MC_DIV` clocks. The system reset request rises after exactly `MC_DIV * 2**CNT_W` running clock edges since arming or the last service.
- R4: The reset request (`sys_rst_o` = 1) lasts exactly `PULSE_OSC` clock cycles.
- R5: The key pair written while armed restarts the count from zero, so regular service prevents the reset.
- R6: Once armed, no write of any value disables the watchdog.
- R7: Key tracking rules:
  - A write of 8'hE1 that does not directly follow a write of 8'h1E, or any other byte, resets the key tracker and has no other effect.
  - Cycles without a write do not break a pending pair.
  - A repeated 8'h1E keeps the pair pending.
- R8: `rst_pin_o` is 1 only while `sys_rst_o` is 1 and `rsto_dis_i` is 0. `sys_rst_o` itself does not depend on `rsto_dis_i`.
- R9: With `idle_i` = 1, the count keeps running when `idle_hold_i` = 0. It pauses when `idle_hold_i` = 1 and resumes without loss when idle ends.
- R10: With `pdown_i` = 1 the count and the machine-cycle phase are frozen.
- R11: When its own reset pulse ends, the watchdog is disabled. Writes during the pulse are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en_i | input | 1 | Write strobe for the service port |
| wr_data_i | input | DATA_W | Byte written to the service port |
| idle_i | input | 1 | System is in idle |
| pdown_i | input | 1 | System is in power-down |
| idle_hold_i | input | 1 | 1: pause the count during idle |
| rsto_dis_i | input | 1 | 1: keep the reset-out pin low |
| sys_rst_o | output | 1 | System reset request from a timeout |
| rst_pin_o | output | 1 | Reset-out pin drive |

## Verification
The bench builds the block with `CNT_W` = 5, `MC_DIV` = 3 and `PULSE_OSC` = 7. A full timeout then takes 96 running clocks instead of about 196 thousand. This brings timeouts, service restarts, idle and power-down pauses, and repeated arm/timeout cycles within a short run. The non-unit prescaler keeps the machine-cycle phase visible, so a mistake in clearing or freezing the phase shifts the reset edge. A short pulse length allows writes to land inside the pulse and the disarm after it to be seen.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   // Progress of the two-byte service key
   typedef enum logic {
      KEY_NONE = 1'b0,
      KEY_HALF = 1'b1
   } key_state_e;

endpackage

// File: rtl/wdt_key_tracker.sv
module wdt_key_tracker
   import wdt_pkg::*;
#(
   parameter int             DATA_W = 8,
   parameter logic [DATA_W-1:0] KEY_A = 8'h1E,
   parameter logic [DATA_W-1:0] KEY_B = 8'hE1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              block_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic              key_ok_o
);

   key_state_e state_q, state_d;

   always_comb begin
      key_ok_o = 1'b0;
      state_d  = state_q;
      if (block_i) begin
         state_d = KEY_NONE;
      end else if (wr_en_i) begin
         key_ok_o = (state_q == KEY_HALF) && (wr_data_i == KEY_B);
         state_d  = (wr_data_i == KEY_A) ? KEY_HALF : KEY_NONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= KEY_NONE;
      else        state_q <= state_d;
   end

endmodule

// File: rtl/wdt_mc_prescaler.sv
module wdt_mc_prescaler #(
   parameter int MC_DIV = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic run_i,
   output logic tick_o
);

   localparam int PRE_W = (MC_DIV > 1) ? $clog2(MC_DIV) : 1;
   localparam logic [PRE_W-1:0] LAST = PRE_W'(MC_DIV - 1);

   logic [PRE_W-1:0] pre_q;

   assign tick_o = run_i && !clear_i && (pre_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
      end else if (clear_i) begin
         pre_q <= '0;
      end else if (run_i) begin
         pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
      end
   end

endmodule

// File: rtl/wdt_core_counter.sv
module wdt_core_counter #(
   parameter int CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             block_i,
   input  logic             arm_i,
   input  logic             tick_i,
   output logic             armed_o,
   output logic [CNT_W-1:0] count_o,
   output logic             overflow_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic             armed_q;
   logic [CNT_W-1:0] count_q;

   assign overflow_o = armed_q && tick_i && !arm_i && (count_q == CNT_MAX);
   assign armed_o    = armed_q;
   assign count_o    = count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         count_q <= '0;
      end else if (block_i) begin
         armed_q <= 1'b0;
         count_q <= '0;
      end else if (arm_i) begin
         armed_q <= 1'b1;
         count_q <= '0;
      end else if (overflow_o) begin
         armed_q <= 1'b0;
         count_q <= '0;
      end else if (armed_q && tick_i) begin
         count_q <= count_q + 1'b1;
      end
   end

endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen #(
   parameter int PULSE_LEN = 98
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic active_o
);

   localparam int PW = $clog2(PULSE_LEN + 1);

   logic [PW-1:0] left_q;

   assign active_o = (left_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (start_i && !active_o) begin
         left_q <= PW'(PULSE_LEN);
      end else if (active_o) begin
         left_q <= left_q - 1'b1;
      end
   end

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
   parameter int DATA_W    = 8,
   parameter int CNT_W     = 14,
   parameter int MC_DIV    = 12,
   parameter int PULSE_OSC = 98,
   parameter logic [DATA_W-1:0] KEY_A = 8'h1E,
   parameter logic [DATA_W-1:0] KEY_B = 8'hE1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              idle_i,
   input  logic              pdown_i,
   input  logic              idle_hold_i,
   input  logic              rsto_dis_i,
   output logic              sys_rst_o,
   output logic              rst_pin_o
);

   initial begin
      if (CNT_W < 2)        $fatal(1, "keyed_wdt: CNT_W must be at least 2");
      if (MC_DIV < 1)       $fatal(1, "keyed_wdt: MC_DIV must be at least 1");
      if (PULSE_OSC < 1)    $fatal(1, "keyed_wdt: PULSE_OSC must be at least 1");
      if (KEY_A == KEY_B)   $fatal(1, "keyed_wdt: key bytes must differ");
   end

   logic             key_ok;
   logic             armed;
   logic [CNT_W-1:0] count;
   logic             tick;
   logic             overflow;
   logic             pulse_on;
   logic             run;

   // Paused in power-down always, in idle only when configured to
   assign run = armed && !pdown_i && !(idle_i && idle_hold_i);

   wdt_key_tracker #(
      .DATA_W (DATA_W),
      .KEY_A  (KEY_A),
      .KEY_B  (KEY_B)
   ) u_key (
      .clk       (clk),
      .rst_n     (rst_n),
      .block_i   (pulse_on),
      .wr_en_i   (wr_en_i),
      .wr_data_i (wr_data_i),
      .key_ok_o  (key_ok)
   );

   wdt_mc_prescaler #(
      .MC_DIV (MC_DIV)
   ) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (key_ok || !armed || pulse_on),
      .run_i   (run),
      .tick_o  (tick)
   );

   wdt_core_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .block_i    (pulse_on),
      .arm_i      (key_ok),
      .tick_i     (tick),
      .armed_o    (armed),
      .count_o    (count),
      .overflow_o (overflow)
   );

   wdt_pulse_gen #(
      .PULSE_LEN (PULSE_OSC)
   ) u_pulse (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (overflow),
      .active_o (pulse_on)
   );

   assign sys_rst_o = pulse_on;
   assign rst_pin_o = pulse_on && !rsto_dis_i;

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
   parameter int CNT_W     = 14,
   parameter int PULSE_OSC = 98
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sys_rst_o,
   input logic             key_ok,
   input logic             armed,
   input logic [CNT_W-1:0] count,
   input logic             tick,
   input logic             idle_i,
   input logic             pdown_i,
   input logic             idle_hold_i
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

   int hi_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         hi_len <= 0;
      else if (sys_rst_o) hi_len <= hi_len + 1;
      else                hi_len <= 0;
   end

   // R1 / R11: a disabled watchdog outside a pulse never starts a reset
   p_quiet_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !sys_rst_o) |=> !sys_rst_o);

   // R2 / R7: only an accepted key arms a disabled watchdog
   p_arm_needs_key_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !key_ok) |=> !armed);

   // R3: one step per machine-cycle tick
   p_step_per_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && tick && !key_ok && count != CNT_MAX) |=> (count == $past(count) + ONE));

   // R4: pulse length checked through a run-length counter
   p_pulse_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!sys_rst_o && hi_len != 0) |-> (hi_len == PULSE_OSC));

   // R5: service restarts the count
   p_service_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && key_ok && !sys_rst_o) |=> (armed && count == '0));

   // R9: idle with the hold option freezes the count
   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && idle_i && idle_hold_i && !key_ok) |=> $stable(count));

   // R10: power-down freezes the count
   p_pdown_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && pdown_i && !key_ok) |=> $stable(count));

   // R11: the watchdog is disarmed for the whole pulse
   p_off_in_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_o |-> !armed);

endmodule

bind keyed_wdt wdt_checker #(
   .CNT_W     (CNT_W),
   .PULSE_OSC (PULSE_OSC)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sys_rst_o   (sys_rst_o),
   .key_ok      (key_ok),
   .armed       (armed),
   .count       (count),
   .tick        (tick),
   .idle_i      (idle_i),
   .pdown_i     (pdown_i),
   .idle_hold_i (idle_hold_i)
);

// File: tb/sim_keyed_wdt.sv
`timescale 1ns/1ps
module sim_keyed_wdt;

   localparam int CNT_W     = 5;
   localparam int MC_DIV    = 3;
   localparam int PULSE_OSC = 7;
   localparam int LIMIT     = MC_DIV * (1 << CNT_W);

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en_i = 1'b0;
   logic [7:0] wr_data_i = 8'h00;
   logic       idle_i = 1'b0;
   logic       pdown_i = 1'b0;
   logic       idle_hold_i = 1'b0;
   logic       rsto_dis_i = 1'b0;
   logic       sys_rst_o;
   logic       rst_pin_o;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   keyed_wdt #(
      .DATA_W    (8),
      .CNT_W     (CNT_W),
      .MC_DIV    (MC_DIV),
      .PULSE_OSC (PULSE_OSC)
   ) u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en_i     (wr_en_i),
      .wr_data_i   (wr_data_i),
      .idle_i      (idle_i),
      .pdown_i     (pdown_i),
      .idle_hold_i (idle_hold_i),
      .rsto_dis_i  (rsto_dis_i),
      .sys_rst_o   (sys_rst_o),
      .rst_pin_o   (rst_pin_o)
   );

   // Behavioural reference: elapsed running clocks since the last arm/service
   bit m_on;
   bit m_half;
   int m_elapsed;
   int m_pulse;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_on = 0; m_half = 0; m_elapsed = 0; m_pulse = 0;
      end else if (m_pulse > 0) begin
         m_pulse = m_pulse - 1;
         m_half  = 0;
      end else begin
         bit good;
         good = wr_en_i && (wr_data_i == 8'hE1) && m_half;
         if (wr_en_i) m_half = (wr_data_i == 8'h1E);
         if (good) begin
            m_on = 1; m_elapsed = 0;
         end else if (m_on && !pdown_i && !(idle_i && idle_hold_i)) begin
            m_elapsed = m_elapsed + 1;
            if (m_elapsed == LIMIT) begin
               m_on = 0; m_elapsed = 0; m_pulse = PULSE_OSC;
            end
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Per-cycle comparison against the model (R3 R4 R8)
   always @(negedge clk) begin
      if (rst_n) begin
         check(sys_rst_o == (m_pulse > 0), "R3/R4 model sys_rst", sys_rst_o, m_pulse > 0);
         check(rst_pin_o == ((m_pulse > 0) && !rsto_dis_i), "R8 model pin", rst_pin_o,
               (m_pulse > 0) && !rsto_dis_i);
      end
   end

   task automatic wr(input logic [7:0] d);
      wr_en_i = 1'b1; wr_data_i = d;
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   task automatic arm();
      wr(8'h1E); wr(8'hE1);
   endtask

   task automatic wait_rise(input int max, output int k);
      k = 0;
      while (!sys_rst_o && k < max) begin
         @(negedge clk); k++;
      end
   endtask

   task automatic pulse_len(output int n);
      n = 0;
      while (sys_rst_o) begin
         n++; @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int k;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(sys_rst_o == 0 && rst_pin_o == 0, "R1 reset state", sys_rst_o, 0);

      // R1: no key, no reset
      wait_rise(300, k);
      check(k == 300, "R1 disabled after reset", k, 300);

      // R7: bad sequences
      wr(8'hE1);
      wr(8'h1E); wr(8'h55); wr(8'hE1);
      wr(8'hE1); wr(8'h1E); wr(8'h1F);
      wait_rise(300, k);
      check(k == 300, "R7 wrong key ignored", k, 300);

      // R2 R3 R4 R8: arm and time out
      arm();
      wait_rise(LIMIT + 10, k);
      check(k == LIMIT, "R2/R3 timeout after arming", k, LIMIT);
      check(rst_pin_o == 1, "R8 pin follows request", rst_pin_o, 1);
      wr(8'h1E); wr(8'hE1);        // R11: ignored during pulse
      pulse_len(n);
      check(n == PULSE_OSC - 2, "R4 pulse length (after two writes)", n, PULSE_OSC - 2);

      // R11: disabled after own pulse
      wait_rise(300, k);
      check(k == 300, "R11 disabled after pulse", k, 300);

      // R4: full pulse measured
      arm();
      wait_rise(LIMIT + 10, k);
      pulse_len(n);
      check(n == PULSE_OSC, "R4 pulse length", n, PULSE_OSC);

      // R5: service keeps it alive
      arm();
      for (int i = 0; i < 5; i++) begin
         repeat (60) @(negedge clk);
         check(sys_rst_o == 0, "R5 serviced no reset", sys_rst_o, 0);
         arm();
      end
      wait_rise(LIMIT + 10, k);
      check(k == LIMIT, "R5 timeout from last service", k, LIMIT);
      pulse_len(n);

      // R6: other writes do not disable
      arm();
      repeat (10) @(negedge clk);
      wr(8'h00); wr(8'hFF); wr(8'h1E); wr(8'h55);
      wait_rise(LIMIT + 10, k);
      check(k == LIMIT - 14, "R6 cannot disable", k, LIMIT - 14);
      pulse_len(n);

      // R8: pin disabled
      rsto_dis_i = 1'b1;
      arm();
      wait_rise(LIMIT + 10, k);
      check(sys_rst_o == 1 && rst_pin_o == 0, "R8 pin gated", rst_pin_o, 0);
      pulse_len(n);
      rsto_dis_i = 1'b0;

      // R9: idle without hold keeps counting
      idle_i = 1'b1; idle_hold_i = 1'b0;
      arm();
      wait_rise(LIMIT + 10, k);
      check(k == LIMIT, "R9 idle counts when hold=0", k, LIMIT);
      pulse_len(n);
      idle_i = 1'b0;

      // R9: idle with hold pauses
      idle_hold_i = 1'b1;
      arm();
      repeat (20) @(negedge clk);
      idle_i = 1'b1;
      repeat (50) @(negedge clk);
      idle_i = 1'b0;
      wait_rise(LIMIT + 10, k);
      check(k == LIMIT - 20, "R9 idle pauses when hold=1", k, LIMIT - 20);
      pulse_len(n);
      idle_hold_i = 1'b0;

      // R10: power-down freezes (mid machine cycle)
      arm();
      repeat (31) @(negedge clk);
      pdown_i = 1'b1;
      repeat (40) @(negedge clk);
      pdown_i = 1'b0;
      wait_rise(LIMIT + 10, k);
      check(k == LIMIT - 31, "R10 power-down freezes", k, LIMIT - 31);
      pulse_len(n);

      // R7: repeated first byte, and gaps without writes
      wr(8'h1E); wr(8'h1E); wr(8'hE1);
      wait_rise(LIMIT + 10, k);
      check(k == LIMIT, "R7 repeated first byte arms", k, LIMIT);
      pulse_len(n);
      wr(8'h1E);
      repeat (5) @(negedge clk);
      wr(8'hE1);
      wait_rise(LIMIT + 10, k);
      check(k == LIMIT, "R7 gap between key bytes", k, LIMIT);
      pulse_len(n);

      // R1: hardware reset while armed disables
      arm();
      repeat (50) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      wait_rise(300, k);
      check(k == 300, "R1 hardware reset disarms", k, 300);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule